// File: doc/BRIEF.md
# Receive FIFO Pause Watermark Controller

This block sits beside a receive FIFO and decides when the transmit side of an Ethernet port should emit pause frames. It compares the FIFO fill level, counted in bytes, against a high and a low watermark held in two register words. When the fill level climbs through the high watermark, it requests a pause-on (XOFF) frame and arms itself. When the fill level later falls through the low watermark, it requests a pause-off (XON) frame and disarms. The gap between the two watermarks provides hysteresis, so at most one XON follows each XOFF.

Both watermarks are kept to 8-byte granularity. A single enable bit gates every XON request. The same bit also lets two external request pins trigger XOFF or XON directly. Transmit flow control is allowed either by the auto-negotiation result or, when the port is configured by hand, by a manual enable. Each request output is a level that rises for one event and stays high until its acknowledge input is seen.

Top module: `rx_pause_wm_ctrl`

## Requirements
- R1: After reset both register words read zero and neither request output is asserted.
- R2: The low-threshold word keeps the pause-off enable in bit 31 and the low watermark in bits 15:3. Bits 30:16 and 2:0 ignore writes and read zero, so a write of FFFFFFFFh reads back 8000FFF8h.
- R3: The high-threshold word keeps the high watermark in bits 15:3, and every other bit reads zero. A write of FFFFFFFFh reads back 0000FFF8h.
- R4: When the fill count moves from below the high watermark to greater than or equal to it, an XOFF request is raised and the block arms. The pause-off enable is not needed for this.
- R5: While armed, a fill count that moves from at or above the low watermark to below it raises one XON request and disarms the block. A further fall below the low watermark gives no second XON until the high watermark is crossed again.
- R6: Without a prior high-watermark crossing, a fall below the low watermark or a level that stays below it produces no XON.
- R7: While the pause-off enable is clear, no XON request is produced, whether from a threshold or from a pin.
- R8: With the pause-off enable set, a rising edge on the external XOFF pin raises an XOFF request, and a rising edge on the external XON pin raises an XON request.
- R9: In manual configuration, requests are allowed only when the manual transmit-flow-control enable is 1. Otherwise the auto-negotiated pause result must be 1. Without this permission no request of either kind is raised.
- R10: While the high watermark is less than or equal to the low watermark, threshold crossings raise no request. Pin-triggered requests are unaffected.
- R11: A request stays asserted until its acknowledge is seen. A new event while a request is pending merges into it. An event in the same cycle as the acknowledge keeps the request asserted.
- R12: A request asserts on the first clock edge that samples the triggering count or pin edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register word select: 0 selects the low-threshold word, 1 selects the high-threshold word |
| reg_wdata | input | 32 | Register write data |
| low_word_rd | output | 32 | Read value of the low-threshold word |
| high_word_rd | output | 32 | Read value of the high-threshold word |
| fifo_bytes | input | 16 | Receive FIFO fill level in bytes |
| ext_xoff_pin | input | 1 | External pause-on request pin |
| ext_xon_pin | input | 1 | External pause-off request pin |
| an_tx_pause | input | 1 | Auto-negotiated transmit pause result |
| manual_cfg | input | 1 | Port is configured manually |
| man_tx_fc_en | input | 1 | Manual transmit flow-control enable |
| xoff_req | output | 1 | Pause-on frame request |
| xoff_ack | input | 1 | Pause-on request acknowledge |
| xon_req | output | 1 | Pause-off frame request |
| xon_ack | input | 1 | Pause-off request acknowledge |

## Verification
Some rules are checked by assertions on every cycle:
- register writes reaching the readback with their reserved bits masked;
- requests held until acknowledged;
- no XON request rising while the enable is clear;
- no request rising without flow-control permission;
- no threshold-driven XOFF while the watermarks are invalid.

The hysteresis itself can only be shown by the bench's count sequences. That covers arming on the high crossing, exactly one XON per XOFF, and silence when the level falls or lingers below the low mark without arming. The same holds for merging an event into a pending request, and for when each request rises relative to its trigger.

// File: rtl/pause_wm_pkg.sv
package pause_wm_pkg;

  localparam int REQ_XOFF = 0;
  localparam int REQ_XON  = 1;
  localparam int NUM_REQ  = 2;

  localparam logic SEL_LOW  = 1'b0;
  localparam logic SEL_HIGH = 1'b1;

  // transmit pause allowed: manual setting wins over negotiated result
  function automatic logic fc_permit(input logic manual, input logic man_en,
                                     input logic an_res);
    return manual ? man_en : an_res;
  endfunction

endpackage

// File: rtl/pause_wm_regs.sv
module pause_wm_regs #(
  parameter int DATA_W    = 32,
  parameter int THR_W     = 16,
  parameter int GRAN_BITS = 3,
  parameter int XONE_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [THR_W-1:0]  lo_thr,
  output logic [THR_W-1:0]  hi_thr,
  output logic              xon_en,
  output logic [DATA_W-1:0] lo_word,
  output logic [DATA_W-1:0] hi_word
);
  import pause_wm_pkg::*;

  localparam int FLD_W = THR_W - GRAN_BITS;

  logic [FLD_W-1:0] lo_fld_q, lo_fld_d;
  logic [FLD_W-1:0] hi_fld_q, hi_fld_d;
  logic             xon_en_q, xon_en_d;
  logic             lo_we, hi_we;

  assign lo_we = wr_en && (wr_sel == SEL_LOW);
  assign hi_we = wr_en && (wr_sel == SEL_HIGH);

  always_comb begin
    lo_fld_d = lo_fld_q;
    hi_fld_d = hi_fld_q;
    xon_en_d = xon_en_q;
    if (lo_we) begin
      lo_fld_d = wr_data[THR_W-1:GRAN_BITS];
      xon_en_d = wr_data[XONE_BIT];
    end
    if (hi_we) begin
      hi_fld_d = wr_data[THR_W-1:GRAN_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_fld_q <= '0;
      hi_fld_q <= '0;
      xon_en_q <= 1'b0;
    end else begin
      lo_fld_q <= lo_fld_d;
      hi_fld_q <= hi_fld_d;
      xon_en_q <= xon_en_d;
    end
  end

  assign lo_thr = {lo_fld_q, {GRAN_BITS{1'b0}}};
  assign hi_thr = {hi_fld_q, {GRAN_BITS{1'b0}}};
  assign xon_en = xon_en_q;

  always_comb begin
    lo_word = '0;
    lo_word[THR_W-1:GRAN_BITS] = lo_fld_q;
    lo_word[XONE_BIT] = xon_en_q;
    hi_word = '0;
    hi_word[THR_W-1:GRAN_BITS] = hi_fld_q;
  end

endmodule

// File: rtl/pause_wm_detect.sv
module pause_wm_detect #(
  parameter int CNT_W = 16,
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [THR_W-1:0] lo_thr,
  input  logic [THR_W-1:0] hi_thr,
  input  logic             xon_en,
  input  logic             fc_ok,
  input  logic             pin_xoff,
  input  logic             pin_xon,
  output logic             evt_xoff,
  output logic             evt_xon
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CNT_W-1:0] prev_cnt_q;
  logic             pin_xoff_q, pin_xon_q;
  logic             armed_q, armed_d;

  logic [CMP_W-1:0] cnt_x, prev_x, lo_x, hi_x;
  logic             cfg_ok, rise_hi, fall_lo;
  logic             thr_xoff, thr_xon, pin_xoff_evt, pin_xon_evt;

  always_comb begin
    cnt_x  = CMP_W'(cnt);
    prev_x = CMP_W'(prev_cnt_q);
    lo_x   = CMP_W'(lo_thr);
    hi_x   = CMP_W'(hi_thr);

    cfg_ok  = hi_x > lo_x;
    rise_hi = (cnt_x >= hi_x) && (prev_x < hi_x);
    fall_lo = (cnt_x < lo_x) && (prev_x >= lo_x);

    thr_xoff = cfg_ok && fc_ok && rise_hi;
    thr_xon  = cfg_ok && fc_ok && xon_en && armed_q && fall_lo;

    pin_xoff_evt = xon_en && fc_ok && pin_xoff && !pin_xoff_q;
    pin_xon_evt  = xon_en && fc_ok && pin_xon && !pin_xon_q;

    evt_xoff = thr_xoff || pin_xoff_evt;
    evt_xon  = thr_xon || pin_xon_evt;

    armed_d = armed_q;
    if (thr_xon)  armed_d = 1'b0;
    if (thr_xoff) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cnt_q <= '0;
      pin_xoff_q <= 1'b0;
      pin_xon_q  <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      prev_cnt_q <= cnt;
      pin_xoff_q <= pin_xoff;
      pin_xon_q  <= pin_xon;
      armed_q    <= armed_d;
    end
  end

endmodule

// File: rtl/pause_req_hold.sv
module pause_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ack,
  output logic req
);

  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (ack) req_d = 1'b0;
    if (evt) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

endmodule

// File: rtl/rx_pause_wm_ctrl.sv
module rx_pause_wm_ctrl #(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int THR_W     = 16,
  parameter int GRAN_BITS = 3,
  parameter int XONE_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] low_word_rd,
  output logic [DATA_W-1:0] high_word_rd,
  input  logic [CNT_W-1:0]  fifo_bytes,
  input  logic              ext_xoff_pin,
  input  logic              ext_xon_pin,
  input  logic              an_tx_pause,
  input  logic              manual_cfg,
  input  logic              man_tx_fc_en,
  output logic              xoff_req,
  input  logic              xoff_ack,
  output logic              xon_req,
  input  logic              xon_ack
);
  import pause_wm_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [THR_W-1:0]   lo_thr, hi_thr;
  logic               xon_en, fc_ok;
  logic [NUM_REQ-1:0] evt_v, ack_v, req_v;

  assign fc_ok = fc_permit(manual_cfg, man_tx_fc_en, an_tx_pause);

  pause_wm_regs #(
    .DATA_W(DATA_W), .THR_W(THR_W), .GRAN_BITS(GRAN_BITS), .XONE_BIT(XONE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .wr_en(reg_wr_en), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .lo_thr(lo_thr), .hi_thr(hi_thr), .xon_en(xon_en),
    .lo_word(low_word_rd), .hi_word(high_word_rd)
  );

  pause_wm_detect #(.CNT_W(CNT_W), .THR_W(THR_W)) u_detect (
    .clk(clk), .rst_n(rst_core_n),
    .cnt(fifo_bytes), .lo_thr(lo_thr), .hi_thr(hi_thr),
    .xon_en(xon_en), .fc_ok(fc_ok),
    .pin_xoff(ext_xoff_pin), .pin_xon(ext_xon_pin),
    .evt_xoff(evt_v[REQ_XOFF]), .evt_xon(evt_v[REQ_XON])
  );

  assign ack_v[REQ_XOFF] = xoff_ack;
  assign ack_v[REQ_XON]  = xon_ack;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    pause_req_hold u_hold (
      .clk(clk), .rst_n(rst_core_n),
      .evt(evt_v[g]), .ack(ack_v[g]), .req(req_v[g])
    );
  end

  assign xoff_req = req_v[REQ_XOFF];
  assign xon_req  = req_v[REQ_XON];

endmodule

// File: rtl/pause_wm_chk.sv
module pause_wm_chk #(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int THR_W     = 16,
  parameter int GRAN_BITS = 3,
  parameter int XONE_BIT  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] low_word_rd,
  input logic [DATA_W-1:0] high_word_rd,
  input logic              ext_xoff_pin,
  input logic              an_tx_pause,
  input logic              manual_cfg,
  input logic              man_tx_fc_en,
  input logic              xoff_req,
  input logic              xoff_ack,
  input logic              xon_req,
  input logic              xon_ack
);

  localparam logic [DATA_W-1:0] FLD_MASK =
    (DATA_W'(1) << THR_W) - (DATA_W'(1) << GRAN_BITS);
  localparam logic [DATA_W-1:0] LO_MASK = FLD_MASK | (DATA_W'(1) << XONE_BIT);

  logic fc_ok_port, cfg_ok_port;
  assign fc_ok_port  = manual_cfg ? man_tx_fc_en : an_tx_pause;
  assign cfg_ok_port = high_word_rd[THR_W-1:GRAN_BITS] > low_word_rd[THR_W-1:GRAN_BITS];

  p_lo_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_sel) |=> (low_word_rd == ($past(reg_wdata) & LO_MASK)));

  p_hi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_sel) |=> (high_word_rd == ($past(reg_wdata) & FLD_MASK)));

  p_xon_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xon_req) |-> $past(low_word_rd[XONE_BIT]));

  p_xoff_permit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_req) |-> $past(fc_ok_port));

  p_xon_permit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xon_req) |-> $past(fc_ok_port));

  p_xoff_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_req) |-> ($past(cfg_ok_port) ||
                         ($past(ext_xoff_pin) && !$past(ext_xoff_pin, 2))));

  p_xoff_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_req && !xoff_ack) |=> xoff_req);

  p_xon_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_req && !xon_ack) |=> xon_req);

endmodule

bind rx_pause_wm_ctrl pause_wm_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .THR_W(THR_W),
  .GRAN_BITS(GRAN_BITS), .XONE_BIT(XONE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_core_n),
  .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .low_word_rd(low_word_rd), .high_word_rd(high_word_rd),
  .ext_xoff_pin(ext_xoff_pin), .an_tx_pause(an_tx_pause),
  .manual_cfg(manual_cfg), .man_tx_fc_en(man_tx_fc_en),
  .xoff_req(xoff_req), .xoff_ack(xoff_ack),
  .xon_req(xon_req), .xon_ack(xon_ack)
);

// File: tb/rx_pause_wm_ctrl_test.sv
module rx_pause_wm_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] low_word_rd, high_word_rd;
  logic [15:0] fifo_bytes;
  logic        ext_xoff_pin, ext_xon_pin;
  logic        an_tx_pause, manual_cfg, man_tx_fc_en;
  logic        xoff_req, xoff_ack, xon_req, xon_ack;

  int checks = 0;
  int errors = 0;

  rx_pause_wm_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .low_word_rd(low_word_rd), .high_word_rd(high_word_rd),
    .fifo_bytes(fifo_bytes),
    .ext_xoff_pin(ext_xoff_pin), .ext_xon_pin(ext_xon_pin),
    .an_tx_pause(an_tx_pause), .manual_cfg(manual_cfg), .man_tx_fc_en(man_tx_fc_en),
    .xoff_req(xoff_req), .xoff_ack(xoff_ack),
    .xon_req(xon_req), .xon_ack(xon_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {count, expected xoff, expected xon}; lo=64, hi=256
  localparam logic [17:0] VEC [12] = '{
    {16'd0,   1'b0, 1'b0},
    {16'd100, 1'b0, 1'b0},
    {16'd40,  1'b0, 1'b0},  // R6 fall below low, not armed
    {16'd256, 1'b1, 1'b0},  // R4 reach high exactly
    {16'd300, 1'b0, 1'b0},
    {16'd200, 1'b0, 1'b0},
    {16'd63,  1'b0, 1'b1},  // R5 fall below low
    {16'd50,  1'b0, 1'b0},  // R6 stays below
    {16'd70,  1'b0, 1'b0},
    {16'd60,  1'b0, 1'b0},  // R5 disarmed, no second XON
    {16'd500, 1'b1, 1'b0},  // R4
    {16'd10,  1'b0, 1'b1}   // R5
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic ack_both();
    xoff_ack = 1'b1; xon_ack = 1'b1;
    @(negedge clk);
    xoff_ack = 1'b0; xon_ack = 1'b0;
  endtask

  task automatic step(input logic [15:0] c, input logic ex_off, input logic ex_on,
                      input string tag);
    @(negedge clk);
    fifo_bytes = c;
    #1;
    if (ex_off) chk(xoff_req, 0, "R12 xoff before edge");
    if (ex_on)  chk(xon_req, 0, "R12 xon before edge");
    @(negedge clk);
    chk(xoff_req, ex_off, {tag, " xoff"});
    chk(xon_req,  ex_on,  {tag, " xon"});
    ack_both();
  endtask

  task automatic pin_pulse(input logic which_xon, input logic ex_off, input logic ex_on,
                           input string tag);
    @(negedge clk);
    if (which_xon) ext_xon_pin = 1'b1; else ext_xoff_pin = 1'b1;
    @(negedge clk);
    ext_xon_pin = 1'b0; ext_xoff_pin = 1'b0;
    chk(xoff_req, ex_off, {tag, " xoff"});
    chk(xon_req,  ex_on,  {tag, " xon"});
    ack_both();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    fifo_bytes = '0; ext_xoff_pin = 1'b0; ext_xon_pin = 1'b0;
    an_tx_pause = 1'b1; manual_cfg = 1'b0; man_tx_fc_en = 1'b0;
    xoff_ack = 1'b0; xon_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(low_word_rd, 32'h0, "R1 low word");
    chk(high_word_rd, 32'h0, "R1 high word");
    chk({xoff_req, xon_req}, 2'b00, "R1 requests");

    // R2 / R3 field layout
    wr(1'b0, 32'hFFFF_FFFF);
    chk(low_word_rd, 32'h8000_FFF8, "R2 low readback");
    wr(1'b1, 32'hFFFF_FFFF);
    chk(high_word_rd, 32'h0000_FFF8, "R3 high readback");
    wr(1'b0, 32'h8000_0047);
    chk(low_word_rd, 32'h8000_0040, "R2 granularity");
    wr(1'b1, 32'h0000_0100);
    chk(high_word_rd, 32'h0000_0100, "R3 high program");

    // table walk: R4 R5 R6 R12
    for (int i = 0; i < 12; i++)
      step(VEC[i][17:2], VEC[i][1], VEC[i][0], $sformatf("R4/R5/R6 vec%0d", i));

    // R7 enable clear
    wr(1'b0, 32'h0000_0040);
    step(16'd300, 1'b1, 1'b0, "R4 xoff without enable");
    step(16'd10, 1'b0, 1'b0, "R7 threshold xon blocked");
    pin_pulse(1'b1, 1'b0, 1'b0, "R7 pin xon blocked");
    pin_pulse(1'b0, 1'b0, 1'b0, "R7 pin xoff blocked");
    wr(1'b0, 32'h8000_0040);
    step(16'd5, 1'b0, 1'b0, "R6 stays below low");
    step(16'd300, 1'b1, 1'b0, "R4 rearm");
    step(16'd10, 1'b0, 1'b1, "R5 xon");

    // R8 pins
    pin_pulse(1'b0, 1'b1, 1'b0, "R8 pin xoff");
    pin_pulse(1'b1, 1'b0, 1'b1, "R8 pin xon");

    // R9 permission
    manual_cfg = 1'b1; man_tx_fc_en = 1'b0; an_tx_pause = 1'b1;
    step(16'd300, 1'b0, 1'b0, "R9 manual disabled rise");
    pin_pulse(1'b0, 1'b0, 1'b0, "R9 manual disabled pin");
    step(16'd10, 1'b0, 1'b0, "R9 manual disabled fall");
    man_tx_fc_en = 1'b1; an_tx_pause = 1'b0;
    step(16'd300, 1'b1, 1'b0, "R9 manual enabled rise");
    step(16'd10, 1'b0, 1'b1, "R9 manual enabled fall");
    manual_cfg = 1'b0; man_tx_fc_en = 1'b0;
    step(16'd300, 1'b0, 1'b0, "R9 negotiated off");
    step(16'd10, 1'b0, 1'b0, "R9 negotiated off fall");
    an_tx_pause = 1'b1;

    // R10 invalid watermarks
    wr(1'b1, 32'h0000_0040);
    step(16'd300, 1'b0, 1'b0, "R10 equal marks rise");
    step(16'd10, 1'b0, 1'b0, "R10 equal marks fall");
    pin_pulse(1'b0, 1'b1, 1'b0, "R10 pin still works");
    wr(1'b1, 32'h0000_0100);

    // R11 hold, merge, ack collision
    @(negedge clk); ext_xoff_pin = 1'b1;
    @(negedge clk); ext_xoff_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(xoff_req, 1, "R11 held without ack");
    ext_xoff_pin = 1'b1;
    @(negedge clk); ext_xoff_pin = 1'b0;
    chk(xoff_req, 1, "R11 merged event");
    @(negedge clk);
    ext_xoff_pin = 1'b1; xoff_ack = 1'b1;
    @(negedge clk);
    ext_xoff_pin = 1'b0;
    chk(xoff_req, 1, "R11 event wins over ack");
    @(negedge clk);
    xoff_ack = 1'b0;
    chk(xoff_req, 0, "R11 cleared by ack");
    chk(xon_req, 0, "R11 xon untouched");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule